// File: doc/BRIEF.md
# Masked Time-of-Day Alarm and Shared Interrupt Line

This block watches the running BCD clock and raises an alarm when the programmed alarm time is reached. The alarm can be set for one moment in the month, or it can repeat every day, hour, minute or second. Four ignore bits, one on each alarm field, choose how many fields must match. A match latches an alarm flag. If the alarm is enabled, the flag pulls an active-low interrupt line. Software releases the line by accessing the status register, and the flag is cleared when that access ends.

The same interrupt line is shared with two other sources: a watchdog request that comes from a neighbouring block, and a square-wave test output used to measure the oscillator. The block decides which source drives the line. When the system runs from standby power, the alarm reaches the line only if a second enable bit is also set. A power-restore strobe clears all the enables but leaves the flag alone, so software can still see an alarm that happened during the transition.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After synchronous reset, every register reads 0x00 and `irq_n` is 1.
- R2: Register map on `bus_addr`:
  - 0 is status. It reads watchdog flag in bit 7, alarm flag in bit 6 and battery-low in bit 4. All other bits read 0, and writes to it change no bit.
  - 1 is control. Bit 7 is the alarm enable and bit 5 is the standby alarm enable. Its other bits read 0.
  - 2 to 5 are the alarm seconds, minutes, hours and date registers. Each holds all 8 bits written, and bit 7 of each is that field's ignore bit.
  - 6 holds the test enable in bit 0.
  - 7 reads 0x00.
- R3: With the ignore bits written as {date,hour,min,sec}, the alarm rate is:
  - 1111: every tick.
  - 1110: seconds equal.
  - 1100: minutes and seconds equal.
  - 1000: hours, minutes and seconds equal.
  - 0000: all four fields equal.
- R4: Any other ignore pattern makes the alarm fire on every tick.
- R5: The time inputs are compared only in a cycle with `sec_tick` high. On a qualifying match the alarm flag reads 1 from the next cycle on. With no tick, the flag never sets.
- R6: With the alarm flag set, `irq_n` is 0 when the alarm enable is 1. While `on_backup` is 1, it also needs the standby alarm enable to be 1.
- R7: A read or write of the status register releases the alarm part of `irq_n` from the first cycle of the access. The flag keeps reading 1 until `bus_sel` falls, and reads 0 from the cycle after that.
- R8: A match that occurs while a status access is open leaves the flag set once the access ends.
- R9: `pwr_restore` clears the alarm enable, the standby alarm enable and the test enable. It does not clear the alarm flag, and a match in the same cycle still sets the flag.
- R10: When `osc_run` is 1, the test enable is 1, the alarm enable is 0, and either `wdog_steer` or `wdog_idle` is 1, `irq_n` starts at 1 and toggles on every `fsq_tick`. Otherwise the test waveform holds `irq_n` at 1.
- R11: `wdog_req` drives `irq_n` to 0 only when `wdog_steer` is 0. With `wdog_steer` 0 and `wdog_idle` 0, the test waveform is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current date, BCD |
| sec_tick | input | 1 | One-cycle pulse once per second, time inputs already updated |
| fsq_tick | input | 1 | Pulse at twice the test output frequency |
| osc_run | input | 1 | Oscillator running |
| on_backup | input | 1 | System is on standby power |
| pwr_restore | input | 1 | Power-restore strobe |
| bus_sel | input | 1 | Register access active (may span cycles) |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| batt_low | input | 1 | Battery-low indication for status bit 4 |
| wdog_flag | input | 1 | Watchdog flag for status bit 7 |
| wdog_req | input | 1 | Watchdog interrupt request |
| wdog_steer | input | 1 | Watchdog routed to reset (1) or to this line (0) |
| wdog_idle | input | 1 | Watchdog register is zero |
| irq_n | output | 1 | Active-low shared interrupt |

## Verification
Two events can fall in the same cycle, and the bench provokes both on purpose.

The first is a second tick that matches while a status access is still open. The bench holds `bus_sel` on the status address across several cycles and raises `sec_tick` in the middle. After `bus_sel` falls, it judges the result from the status read-back and from `irq_n`: the flag must survive and the line must fall again.

The second is a power-restore strobe in the same cycle as a matching tick. The bench expects the enables to be cleared and the flag to be set.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int REG_AW     = 3;
    localparam int REG_DW     = 8;
    localparam int NUM_FIELDS = 4;
    localparam int FIELD_W    = 7;
    localparam int ALARM_BASE = 2;

    localparam int BIT_WF   = 7;
    localparam int BIT_AF   = 6;
    localparam int BIT_BLF  = 4;
    localparam int BIT_AE   = 7;
    localparam int BIT_ABE  = 5;
    localparam int BIT_TEST = 0;

    typedef enum logic [REG_AW-1:0] {
        A_STATUS = 3'd0,
        A_CTL    = 3'd1,
        A_ASEC   = 3'd2,
        A_AMIN   = 3'd3,
        A_AHOUR  = 3'd4,
        A_ADATE  = 3'd5,
        A_TEST   = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] date;
    } bcd_time_t;

    typedef struct packed {
        logic               ign;
        logic [FIELD_W-1:0] val;
    } alarm_field_t;

    typedef enum logic [2:0] {
        RATE_EVERY,
        RATE_S,
        RATE_MS,
        RATE_HMS,
        RATE_DHMS
    } rate_e;

    // ignore bits ordered {date, hour, min, sec}
    function automatic rate_e decode_rate(input logic [NUM_FIELDS-1:0] ign);
        case (ign)
            4'b1110: return RATE_S;
            4'b1100: return RATE_MS;
            4'b1000: return RATE_HMS;
            4'b0000: return RATE_DHMS;
            default: return RATE_EVERY;
        endcase
    endfunction

    function automatic logic [NUM_FIELDS-1:0] rate_need(input rate_e r);
        case (r)
            RATE_S:    return 4'b0001;
            RATE_MS:   return 4'b0011;
            RATE_HMS:  return 4'b0111;
            RATE_DHMS: return 4'b1111;
            default:   return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_restore,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            addr,
    input  logic [REG_DW-1:0]            wdata,
    input  logic                         af,
    input  logic                         wdog_flag,
    input  logic                         batt_low,
    output alarm_field_t [NUM_FIELDS-1:0] aset,
    output logic                         ae,
    output logic                         abe,
    output logic                         test_en,
    output logic [REG_DW-1:0]            rdata
);

    alarm_field_t field_q [NUM_FIELDS];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(ALARM_BASE + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                field_q[i] <= '0;
            end else if (wr_en && addr == MY_ADDR) begin
                field_q[i] <= alarm_field_t'(wdata);
            end
        end
        assign aset[i] = field_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ae      <= 1'b0;
            abe     <= 1'b0;
            test_en <= 1'b0;
        end else if (pwr_restore) begin
            ae      <= 1'b0;
            abe     <= 1'b0;
            test_en <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CTL) begin
                ae  <= wdata[BIT_AE];
                abe <= wdata[BIT_ABE];
            end
            if (addr == A_TEST) begin
                test_en <= wdata[BIT_TEST];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_STATUS: begin
                rdata[BIT_WF]  = wdog_flag;
                rdata[BIT_AF]  = af;
                rdata[BIT_BLF] = batt_low;
            end
            A_CTL: begin
                rdata[BIT_AE]  = ae;
                rdata[BIT_ABE] = abe;
            end
            A_ASEC:  rdata = field_q[0];
            A_AMIN:  rdata = field_q[1];
            A_AHOUR: rdata = field_q[2];
            A_ADATE: rdata = field_q[3];
            A_TEST:  rdata[BIT_TEST] = test_en;
            default: rdata = '0;
        endcase
    end

    assert_restore_clears_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_restore |=> (!ae && !abe && !test_en));

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
(
    input  alarm_field_t [NUM_FIELDS-1:0] aset,
    input  bcd_time_t                    now,
    input  logic                         sec_tick,
    output logic                         hit
);

    logic [FIELD_W-1:0]    tval [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] ign;
    logic [NUM_FIELDS-1:0] need;
    rate_e                 rate;

    always_comb begin
        tval[0] = FIELD_W'(now.sec);
        tval[1] = FIELD_W'(now.min);
        tval[2] = FIELD_W'(now.hour);
        tval[3] = FIELD_W'(now.date);
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign eq[i]  = (aset[i].val == tval[i]);
        assign ign[i] = aset[i].ign;
    end

    assign rate = decode_rate(ign);
    assign need = rate_need(rate);
    assign hit  = sec_tick && (&(eq | ~need));

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic acc_status,
    output logic af,
    output logic access_hold
);

    logic pend;
    logic rehit;

    always_ff @(posedge clk) begin
        if (rst) begin
            af    <= 1'b0;
            pend  <= 1'b0;
            rehit <= 1'b0;
        end else if (acc_status) begin
            pend <= 1'b1;
            if (hit) begin
                rehit <= 1'b1;
                af    <= 1'b1;
            end
        end else if (pend) begin
            af    <= hit || rehit;
            pend  <= 1'b0;
            rehit <= 1'b0;
        end else if (hit) begin
            af <= 1'b1;
        end
    end

    assign access_hold = acc_status || pend;

    assert_flag_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(hit));

    assert_flag_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(af) |-> ($past(pend) && !$past(acc_status)));

    assert_pend_closes_R7: assert property (@(posedge clk) disable iff (rst)
        (pend && !acc_status) |=> !pend);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic af,
    input  logic ae,
    input  logic abe,
    input  logic on_backup,
    input  logic access_hold,
    input  logic wdog_req,
    input  logic wdog_steer,
    input  logic wdog_idle,
    input  logic osc_run,
    input  logic test_en,
    input  logic fsq_tick,
    output logic irq_n
);

    logic alarm_req;
    logic wd_req;
    logic ft_active;
    logic wave;

    assign alarm_req = af && ae && (!on_backup || abe) && !access_hold;
    assign wd_req    = wdog_req && !wdog_steer;
    assign ft_active = osc_run && test_en && !ae && (wdog_steer || wdog_idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b1;
        end else if (!ft_active) begin
            wave <= 1'b1;
        end else if (fsq_tick) begin
            wave <= !wave;
        end
    end

    assign irq_n = !(alarm_req || wd_req || (ft_active && !wave));

    assert_wave_released_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!ft_active) |-> wave);

    assert_wave_holds_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(ft_active) && !$past(fsq_tick)) |-> $stable(wave));

    assert_wdog_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (wdog_req && !wdog_steer) |-> !irq_n);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_date,
    input  logic              sec_tick,
    input  logic              fsq_tick,
    input  logic              osc_run,
    input  logic              on_backup,
    input  logic              pwr_restore,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic              batt_low,
    input  logic              wdog_flag,
    input  logic              wdog_req,
    input  logic              wdog_steer,
    input  logic              wdog_idle,
    output logic              irq_n
);

    alarm_field_t [NUM_FIELDS-1:0] aset;
    bcd_time_t                     now;
    logic ae, abe, test_en, af, hit, access_hold, acc_status, wr_en;

    assign now        = '{sec: cur_sec, min: cur_min, hour: cur_hour, date: cur_date};
    assign wr_en      = bus_sel && bus_wr;
    assign acc_status = bus_sel && (bus_addr == A_STATUS);

    alarm_regs u_regs (
        .clk(clk), .rst(rst), .pwr_restore(pwr_restore), .wr_en(wr_en),
        .addr(bus_addr), .wdata(bus_wdata), .af(af), .wdog_flag(wdog_flag),
        .batt_low(batt_low), .aset(aset), .ae(ae), .abe(abe),
        .test_en(test_en), .rdata(bus_rdata)
    );

    alarm_match u_match (
        .aset(aset), .now(now), .sec_tick(sec_tick), .hit(hit)
    );

    alarm_flag u_flag (
        .clk(clk), .rst(rst), .hit(hit), .acc_status(acc_status),
        .af(af), .access_hold(access_hold)
    );

    irq_arbiter u_arb (
        .clk(clk), .rst(rst), .af(af), .ae(ae), .abe(abe),
        .on_backup(on_backup), .access_hold(access_hold), .wdog_req(wdog_req),
        .wdog_steer(wdog_steer), .wdog_idle(wdog_idle), .osc_run(osc_run),
        .test_en(test_en), .fsq_tick(fsq_tick), .irq_n(irq_n)
    );

    assert_access_releases_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_status && !(wdog_req && !wdog_steer) && !test_en) |-> irq_n);

endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_date = '0;
    logic       sec_tick = 0, fsq_tick = 0, osc_run = 0, on_backup = 0, pwr_restore = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       batt_low = 0, wdog_flag = 0, wdog_req = 0, wdog_steer = 0, wdog_idle = 1;
    logic       irq_n;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #5 clk = ~clk;

    rtc_alarm_irq dut (
        .clk(clk), .rst(rst), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .sec_tick(sec_tick),
        .fsq_tick(fsq_tick), .osc_run(osc_run), .on_backup(on_backup),
        .pwr_restore(pwr_restore), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .batt_low(batt_low), .wdog_flag(wdog_flag), .wdog_req(wdog_req),
        .wdog_steer(wdog_steer), .wdog_idle(wdog_idle), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h, input logic [5:0] dt);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        #1;
    endtask

    task automatic fsq_pulse();
        @(negedge clk);
        fsq_tick = 1;
        @(negedge clk);
        fsq_tick = 0;
        #1;
    endtask

    // read status, return alarm flag bit 6 (read also clears it)
    task automatic flag_probe(input string req, input logic exp);
        logic [7:0] d;
        bus_read(3'd0, d);
        chk(req, {7'd0, d[6]}, {7'd0, exp});
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] dt);
        bus_write(3'd2, s);
        bus_write(3'd3, m);
        bus_write(3'd4, h);
        bus_write(3'd5, dt);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        #1 chk("R1 irq during reset", {7'd0, irq_n}, 8'h01);
        repeat (3) @(negedge clk);
        rst = 0;
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), d);
            chk("R1 reg after reset", d, 8'h00);
        end
        #1 chk("R1 irq idle", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        bus_write(3'd2, 8'hA5); bus_read(3'd2, d); chk("R2 alarm sec readback", d, 8'hA5);
        bus_write(3'd5, 8'h3C); bus_read(3'd5, d); chk("R2 alarm date readback", d, 8'h3C);
        bus_write(3'd1, 8'hFF); bus_read(3'd1, d); chk("R2 control bits", d, 8'hA0);
        bus_write(3'd1, 8'h00);
        bus_write(3'd6, 8'hFF); bus_read(3'd6, d); chk("R2 test bit", d, 8'h01);
        bus_write(3'd6, 8'h00);
        bus_write(3'd7, 8'hFF); bus_read(3'd7, d); chk("R2 spare reads zero", d, 8'h00);
        batt_low = 1; wdog_flag = 1;
        bus_write(3'd0, 8'hFF); bus_read(3'd0, d); chk("R2 status composition", d, 8'h90);
        batt_low = 0; wdog_flag = 0;
    endtask

    task automatic t_masks();
        // R3 seconds only (1110)
        set_alarm(8'h25, 8'h90, 8'h83, 8'h95);
        tick(7'h24, 7'h10, 6'h03, 6'h15); flag_probe("R3 sec mismatch", 0);
        tick(7'h25, 7'h44, 6'h07, 6'h02); flag_probe("R3 sec match", 1);
        // R3 min+sec (1100)
        bus_write(3'd3, 8'h10);
        tick(7'h25, 7'h11, 6'h03, 6'h15); flag_probe("R3 min mismatch", 0);
        tick(7'h25, 7'h10, 6'h22, 6'h01); flag_probe("R3 min sec match", 1);
        // R3 hms (1000)
        bus_write(3'd4, 8'h03);
        tick(7'h25, 7'h10, 6'h04, 6'h15); flag_probe("R3 hour mismatch", 0);
        tick(7'h25, 7'h10, 6'h03, 6'h30); flag_probe("R3 hms match", 1);
        // R3 full (0000)
        bus_write(3'd5, 8'h15);
        tick(7'h25, 7'h10, 6'h03, 6'h16); flag_probe("R3 date mismatch", 0);
        tick(7'h25, 7'h10, 6'h03, 6'h15); flag_probe("R3 full match", 1);
        // R3 every second (1111)
        set_alarm(8'hA5, 8'h90, 8'h83, 8'h95);
        tick(7'h00, 7'h00, 6'h00, 6'h01); flag_probe("R3 every tick", 1);
    endtask

    task automatic t_invalid();
        set_alarm(8'h25, 8'h90, 8'h83, 8'h15);   // 0110
        tick(7'h01, 7'h02, 6'h04, 6'h08); flag_probe("R4 pattern 0110", 1);
        set_alarm(8'h25, 8'h90, 8'h03, 8'h95);   // 1010
        tick(7'h01, 7'h02, 6'h04, 6'h08); flag_probe("R4 pattern 1010", 1);
    endtask

    task automatic t_no_tick();
        set_alarm(8'hA5, 8'h90, 8'h83, 8'h95);
        repeat (5) @(negedge clk);
        flag_probe("R5 no tick no flag", 0);
    endtask

    task automatic t_enable_backup();
        bus_write(3'd1, 8'h80);
        on_backup = 1;
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R6 backup needs second enable", {7'd0, irq_n}, 8'h01);
        bus_write(3'd1, 8'hA0); #1;
        chk("R6 backup both enables", {7'd0, irq_n}, 8'h00);
        on_backup = 0; bus_write(3'd1, 8'h80); #1;
        chk("R6 normal alarm enable", {7'd0, irq_n}, 8'h00);
        bus_write(3'd1, 8'h00); #1;
        chk("R6 disabled", {7'd0, irq_n}, 8'h01);
        flag_probe("R6 flag still set", 1);
    endtask

    task automatic t_access_clear();
        bus_write(3'd1, 8'h80);
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R7 irq before access", {7'd0, irq_n}, 8'h00);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd0;
        #1 chk("R7 irq released first cycle", {7'd0, irq_n}, 8'h01);
        chk("R7 flag visible during access", {7'd0, bus_rdata[6]}, 8'h01);
        repeat (3) @(negedge clk);
        #1 chk("R7 flag held until end", {7'd0, bus_rdata[6]}, 8'h01);
        chk("R7 irq stays released", {7'd0, irq_n}, 8'h01);
        bus_sel = 0;
        @(negedge clk); #1;
        chk("R7 irq after access", {7'd0, irq_n}, 8'h01);
        flag_probe("R7 flag cleared", 0);
        // write access clears too
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        bus_write(3'd0, 8'hFF);
        @(negedge clk); #1;
        chk("R7 irq after write access", {7'd0, irq_n}, 8'h01);
        flag_probe("R7 write clears flag", 0);
    endtask

    task automatic t_hit_in_access();
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd0;
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        @(negedge clk); bus_sel = 0;
        @(negedge clk); #1;
        chk("R8 irq returns after access", {7'd0, irq_n}, 8'h00);
        flag_probe("R8 flag survives", 1);
        bus_write(3'd1, 8'h00);
    endtask

    task automatic t_restore();
        logic [7:0] d;
        bus_write(3'd1, 8'hA0);
        bus_write(3'd6, 8'h01);
        @(negedge clk); pwr_restore = 1; sec_tick = 1;
        @(negedge clk); pwr_restore = 0; sec_tick = 0;
        bus_read(3'd1, d); chk("R9 enables cleared", d, 8'h00);
        bus_read(3'd6, d); chk("R9 test cleared", d, 8'h00);
        flag_probe("R9 flag set across restore", 1);
    endtask

    task automatic t_freq_test();
        osc_run = 1; wdog_steer = 1; wdog_idle = 0;
        bus_write(3'd6, 8'h01); #1;
        chk("R10 wave starts high", {7'd0, irq_n}, 8'h01);
        fsq_pulse(); chk("R10 toggle low", {7'd0, irq_n}, 8'h00);
        fsq_pulse(); chk("R10 toggle high", {7'd0, irq_n}, 8'h01);
        fsq_pulse(); chk("R10 toggle low again", {7'd0, irq_n}, 8'h00);
        @(negedge clk); osc_run = 0; #1;
        chk("R10 oscillator stopped", {7'd0, irq_n}, 8'h01);
        @(negedge clk); osc_run = 1; #1;
        chk("R10 restarts high", {7'd0, irq_n}, 8'h01);
        bus_write(3'd1, 8'h80);
        fsq_pulse(); chk("R10 alarm enable blocks", {7'd0, irq_n}, 8'h01);
        bus_write(3'd1, 8'h00);
        wdog_steer = 0; wdog_idle = 1;
        fsq_pulse(); chk("R10 idle watchdog allows", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_watchdog();
        @(negedge clk); wdog_idle = 0; #1;
        chk("R11 steered watchdog denies test", {7'd0, irq_n}, 8'h01);
        fsq_pulse(); chk("R11 test stays blocked", {7'd0, irq_n}, 8'h01);
        @(negedge clk); wdog_req = 1; #1;
        chk("R11 watchdog drives line", {7'd0, irq_n}, 8'h00);
        @(negedge clk); wdog_steer = 1; #1;
        chk("R11 reset-steered ignored", {7'd0, irq_n}, 8'h01);
        @(negedge clk); wdog_req = 0; bus_write(3'd6, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regmap();
        t_masks();
        t_invalid();
        t_no_tick();
        t_enable_backup();
        t_access_clear();
        t_hit_in_access();
        t_restore();
        t_freq_test();
        t_watchdog();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule